// File: doc/BRIEF.md
# Scaled Radix-4 FFT Tier

This block is one pipeline stage of a decimation-in-frequency FFT assembled from cascaded radix-4 tiers; six of them cover a 4096-point frame. Samples arrive as a stream of 16-bit complex words with a valid strobe. The tier groups every `N` consecutive accepted samples. It holds the first three quarters of a group in three delay memories of `N/4` words each. When the fourth quarter arrives it forms the four radix-4 butterfly legs, rotates each leg by its twiddle factor, shifts right by the programmed scale and saturates. Leg 0 leaves at once. Legs 1 to 3 are parked in the memories and leave while the first three quarters of the next group stream in. The output order is leg 0, 1, 2, 3, each in index order, which is what the next tier (span `N/16`) expects.

Each tier owns a 3-bit scale field, loaded from a shared 8-bit configuration bus by its own write strobe. A mode input adds a fixed two-bit compensation for the radix-4 growth. A 2-bit sticky state reports the worst magnitude seen since the last frame restart, so software can choose the scaling stage by stage. Beside the data the tier forwards a compute-enable flag, a last-phase flag and an active-low group-done marker.

Top module: `fft4_tier`

## Requirements
- R1: After reset `out_val_o` is 0, `done_n_o` is 1, `scale_state_o` is 00, and `comp_en_o` and `last_phase_o` are 0.
- R2: With inputs x[0..N-1] of one group and q = N/4, leg 0 for index n (0 ≤ n < q) is x[n]+x[n+q]+x[n+2q]+x[n+3q]. It is output, after twiddle and scaling, on the clock edge after the input x[n+3q] is accepted.
- R3: With a = x[n], b = x[n+q], c = x[n+2q], d = x[n+3q]: leg 1 = (a−c) − j(b−d), leg 2 = (a+c) − (b+d), leg 3 = (a−c) + j(b−d). They are output in the order leg 1, leg 2, leg 3, each for n = 0..q−1, one sample per accepted input during the first three quarters of the following group.
- R4: Leg k at index n is multiplied by the twiddle exp(−j2πkn/N), held as signed 16-bit Q1.14 parts rounded to nearest. The product is divided by 2^14 with rounding toward minus infinity.
- R5: The rotated value is arithmetically shifted right (floor) by the scale field when `scale_mode_i` = 0, or by the field plus 2 when `scale_mode_i` = 1. Each part is then saturated to [−32768, 32767].
- R6: The scale field is `cfg_data_i[2:0]`, loaded on a clock edge where `cfg_we_i` = 1. `cfg_data_i[7:3]` is ignored, and the field is unchanged while `cfg_we_i` = 0.
- R7: For each part of each leg after the shift, the state code is 10 if the value lies outside [−32768, 32767], 01 if it lies outside [−16384, 16383] but not outside the wider range, and 00 otherwise. The code 11 never appears.
- R8: `scale_state_o` holds the largest code of all legs computed since the last accepted sample with `restart_i` = 1, and that sample clears it to 00.
- R9: `done_n_o` is 0 exactly while the last leg-3 sample (n = q−1) of a group is on the output.
- R10: While `comp_en_i` = 0, inputs are ignored, no output is valid on the following edge, pending legs are dropped and the group position returns to 0. `comp_en_o` and `last_phase_o` repeat `comp_en_i` and `last_phase_i` one cycle later.
- R11: An accepted sample with `restart_i` = 1 is taken as index 0 of a new group, whatever the previous position was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_val_i | input | 1 | Input sample valid |
| in_re_i | input | 16 | Input real part, signed |
| in_im_i | input | 16 | Input imaginary part, signed |
| restart_i | input | 1 | Marks the first sample of a frame |
| comp_en_i | input | 1 | Tier enable; low empties the tier |
| last_phase_i | input | 1 | Last-phase flag from the previous tier |
| cfg_we_i | input | 1 | Write strobe for this tier's scale field |
| cfg_data_i | input | 8 | Shared configuration bus |
| scale_mode_i | input | 1 | 0: shift by field, 1: shift by field + 2 |
| out_val_o | output | 1 | Output sample valid |
| out_re_o | output | 16 | Output real part, signed |
| out_im_o | output | 16 | Output imaginary part, signed |
| comp_en_o | output | 1 | Forwarded enable |
| last_phase_o | output | 1 | Forwarded last-phase flag |
| done_n_o | output | 1 | Low with the last sample of a group |
| scale_state_o | output | 2 | Sticky overflow/scale state |

## Verification
The bench sweeps every shift value in both modes over pseudo-random groups at N=16, with odd negative values, so a shift that truncated toward zero or rounded the twiddle product would mismatch by one LSB. Full-scale and half-scale groups drive the saturation and guard codes; a state register that followed only the latest group would drop back after a benign group without a restart. A partial group followed by a restart catches a design that keeps its old position and so mixes quarters. Dropping the enable in mid-stream catches pending legs that leak out afterwards.

// File: rtl/fft4_pkg.sv
package fft4_pkg;
  localparam int TFRAC = 14;

  typedef struct packed {
    logic signed [15:0] re;
    logic signed [15:0] im;
  } cplx_t;

  typedef enum logic [1:0] {ST_CLEAN = 2'b00, ST_GUARD = 2'b01, ST_SAT = 2'b10} scl_st_e;

  // Q1.14 twiddle part for exp(-j*2*pi*m/n_pts); want_sin selects the imaginary part.
  function automatic logic signed [15:0] tw_part(int m, int n_pts, logic want_sin);
    real ang;
    real v;
    int  r;
    ang = 6.283185307179586 * m / n_pts;
    v   = want_sin ? -$sin(ang) : $cos(ang);
    v   = v * 16384.0;
    r   = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    return 16'(r);
  endfunction

  function automatic scl_st_e classify(logic signed [35:0] v);
    if (v > 36'sd32767 || v < -36'sd32768) return ST_SAT;
    if (v > 36'sd16383 || v < -36'sd16384) return ST_GUARD;
    return ST_CLEAN;
  endfunction

  function automatic logic signed [15:0] clamp16(logic signed [35:0] v);
    if (v > 36'sd32767)  return 16'sh7fff;
    if (v < -36'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction

  function automatic scl_st_e worse(scl_st_e x, scl_st_e y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/fft4_twiddle_rom.sv
module fft4_twiddle_rom
  import fft4_pkg::*;
#(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0]      idx,
  output logic signed [15:0] w_re,
  output logic signed [15:0] w_im
);
  logic signed [15:0] tab_re [N];
  logic signed [15:0] tab_im [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    assign tab_re[g] = tw_part(g, N, 1'b0);
    assign tab_im[g] = tw_part(g, N, 1'b1);
  end

  assign w_re = tab_re[idx];
  assign w_im = tab_im[idx];
endmodule

// File: rtl/fft4_leg.sv
module fft4_leg
  import fft4_pkg::*;
(
  input  logic signed [17:0] y_re,
  input  logic signed [17:0] y_im,
  input  logic signed [15:0] w_re,
  input  logic signed [15:0] w_im,
  input  logic [3:0]         shift,
  output cplx_t              z,
  output scl_st_e            code
);
  logic signed [35:0] pr, pi, tr, ti;

  always_comb begin
    pr = 36'(y_re) * 36'(w_re) - 36'(y_im) * 36'(w_im);
    pi = 36'(y_re) * 36'(w_im) + 36'(y_im) * 36'(w_re);
    tr = (pr >>> TFRAC) >>> shift;
    ti = (pi >>> TFRAC) >>> shift;
    z.re = clamp16(tr);
    z.im = clamp16(ti);
    code = worse(classify(tr), classify(ti));
  end
endmodule

// File: rtl/fft4_delay_bank.sv
module fft4_delay_bank
  import fft4_pkg::*;
#(
  parameter int SPAN = 16,
  localparam int AW = $clog2(SPAN)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    wr_en,
  input  cplx_t         wdata [3],
  output cplx_t         rdata [3]
);
  for (genvar b = 0; b < 3; b++) begin : g_bank
    cplx_t mem [SPAN];
    always_ff @(posedge clk) begin
      if (wr_en[b]) mem[addr] <= wdata[b];
    end
    assign rdata[b] = mem[addr];
  end
endmodule

// File: rtl/fft4_tier.sv
module fft4_tier
  import fft4_pkg::*;
#(
  parameter int N = 64,
  localparam int SPAN = N / 4,
  localparam int AW = $clog2(SPAN),
  localparam int CW = AW + 2,
  localparam int IW = $clog2(N)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_val_i,
  input  logic [15:0] in_re_i,
  input  logic [15:0] in_im_i,
  input  logic        restart_i,
  input  logic        comp_en_i,
  input  logic        last_phase_i,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_data_i,
  input  logic        scale_mode_i,
  output logic        out_val_o,
  output logic [15:0] out_re_o,
  output logic [15:0] out_im_o,
  output logic        comp_en_o,
  output logic        last_phase_o,
  output logic        done_n_o,
  output logic [1:0]  scale_state_o
);
  logic [CW-1:0] cnt;
  logic [2:0]    fld;
  logic          primed;
  scl_st_e       state;

  // named internal events
  logic          accept, fly_fire, grp_last;
  logic [CW-1:0] cnt_eff;
  logic [1:0]    quarter;
  logic [AW-1:0] addr;
  logic [3:0]    shift;
  scl_st_e       worst;
  logic          cfg_unused;

  cplx_t x_in;
  cplx_t rd [3];
  cplx_t wd [3];
  cplx_t z  [4];
  scl_st_e code [4];
  logic signed [17:0] y_re [4];
  logic signed [17:0] y_im [4];
  logic [2:0] wr_en;

  assign cfg_unused = ^cfg_data_i[7:3];
  assign accept   = in_val_i & comp_en_i;
  assign cnt_eff  = restart_i ? '0 : cnt;
  assign quarter  = cnt_eff[CW-1 -: 2];
  assign addr     = cnt_eff[AW-1:0];
  assign fly_fire = accept && (quarter == 2'd3);
  assign grp_last = accept && primed && (quarter == 2'd2) && (addr == AW'(SPAN - 1));
  assign shift    = {1'b0, fld} + (scale_mode_i ? 4'd2 : 4'd0);
  assign x_in.re  = in_re_i;
  assign x_in.im  = in_im_i;

  // radix-4 butterfly: a,b,c from the delay bank, d is the live sample
  always_comb begin
    logic signed [17:0] acr, aci, acsr, acsi, bdr, bdi, bdsr, bdsi;
    acr  = 18'(rd[0].re) - 18'(rd[2].re);
    aci  = 18'(rd[0].im) - 18'(rd[2].im);
    acsr = 18'(rd[0].re) + 18'(rd[2].re);
    acsi = 18'(rd[0].im) + 18'(rd[2].im);
    bdr  = 18'(rd[1].re) - 18'(x_in.re);
    bdi  = 18'(rd[1].im) - 18'(x_in.im);
    bdsr = 18'(rd[1].re) + 18'(x_in.re);
    bdsi = 18'(rd[1].im) + 18'(x_in.im);
    y_re[0] = acsr + bdsr;  y_im[0] = acsi + bdsi;
    y_re[1] = acr + bdi;    y_im[1] = aci - bdr;
    y_re[2] = acsr - bdsr;  y_im[2] = acsi - bdsi;
    y_re[3] = acr - bdi;    y_im[3] = aci + bdr;
  end

  for (genvar k = 0; k < 4; k++) begin : g_leg
    logic signed [15:0] w_re, w_im;
    logic [IW-1:0]      tw_idx;
    assign tw_idx = IW'(k * int'(addr));
    fft4_twiddle_rom #(.N(N)) u_rom (.idx(tw_idx), .w_re(w_re), .w_im(w_im));
    fft4_leg u_leg (
      .y_re(y_re[k]), .y_im(y_im[k]), .w_re(w_re), .w_im(w_im),
      .shift(shift), .z(z[k]), .code(code[k])
    );
  end

  assign worst = worse(worse(code[0], code[1]), worse(code[2], code[3]));

  for (genvar b = 0; b < 3; b++) begin : g_wr
    assign wd[b]    = fly_fire ? z[b+1] : x_in;
    assign wr_en[b] = accept && (fly_fire || (quarter == 2'(b)));
  end

  fft4_delay_bank #(.SPAN(SPAN)) u_bank (
    .clk(clk), .addr(addr), .wr_en(wr_en), .wdata(wd), .rdata(rd)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;  fld <= '0;  primed <= 1'b0;  state <= ST_CLEAN;
      out_val_o <= 1'b0;  out_re_o <= '0;  out_im_o <= '0;
      comp_en_o <= 1'b0;  last_phase_o <= 1'b0;  done_n_o <= 1'b1;
    end else begin
      comp_en_o    <= comp_en_i;
      last_phase_o <= last_phase_i;
      if (cfg_we_i) fld <= cfg_data_i[2:0];
      if (!comp_en_i) begin
        cnt <= '0;
        primed <= 1'b0;
      end else if (accept) begin
        cnt <= cnt_eff + 1'b1;
        if (fly_fire && addr == AW'(SPAN - 1)) primed <= 1'b1;
      end
      if (accept && restart_i)  state <= ST_CLEAN;
      else if (fly_fire)        state <= worse(state, worst);
      out_val_o <= fly_fire || (accept && primed);
      done_n_o  <= !grp_last;
      if (accept) begin
        out_re_o <= fly_fire ? z[0].re : rd[quarter].re;
        out_im_o <= fly_fire ? z[0].im : rd[quarter].im;
      end
    end
  end

  assign scale_state_o = state;

  assert_outval_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_val_o |-> $past(accept));
  assert_state_legal_R7: assert property (@(posedge clk) disable iff (rst)
    scale_state_o != 2'b11);
  assert_sat_reported_R7: assert property (@(posedge clk) disable iff (rst)
    (fly_fire && worst == ST_SAT) |=> scale_state_o == 2'b10);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (scale_state_o < $past(scale_state_o)) |-> $past(accept && restart_i));
  assert_done_with_data_R9: assert property (@(posedge clk) disable iff (rst)
    !done_n_o |-> out_val_o);
  assert_idle_when_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    !comp_en_i |=> !out_val_o);
endmodule

// File: tb/fft4_tier_tb.sv
`timescale 1ns/1ps
module fft4_tier_tb;
  localparam int N = 16;
  localparam int Q = N / 4;

  logic clk = 1'b0, rst = 1'b1;
  logic in_val_i = 0, restart_i = 0, comp_en_i = 1, last_phase_i = 0;
  logic cfg_we_i = 0, scale_mode_i = 0;
  logic [7:0]  cfg_data_i = '0;
  logic [15:0] in_re_i = '0, in_im_i = '0;
  logic out_val_o, comp_en_o, last_phase_o, done_n_o;
  logic [15:0] out_re_o, out_im_o;
  logic [1:0]  scale_state_o;

  fft4_tier #(.N(N)) u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int exp_re [4096];
  int exp_im [4096];
  int exp_leg [4096];
  int exp_last [4096];
  int wr = 0, rd = 0;
  int cur_field = 0, cur_mode = 0, st_exp = 0;
  int lcg = 12345;
  int xr [N];
  int xi [N];
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd(input int amp);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) % (2 * amp + 1)) - amp;
  endfunction

  function automatic longint fdiv(input longint p, input int sh);
    longint d, q;
    d = longint'(1) << sh;
    q = p / d;
    if ((p % d) != 0 && p < 0) q = q - 1;
    return q;
  endfunction

  function automatic int twid(input int m, input bit imag);
    real a;
    a = 2.0 * 3.14159265358979 * m / N;
    if (imag) return $rtoi($floor(-$sin(a) * 16384.0 + 0.5));
    return $rtoi($floor($cos(a) * 16384.0 + 0.5));
  endfunction

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int grade(input longint v);
    if (v > 32767 || v < -32768) return 2;
    if (v > 16383 || v < -16384) return 1;
    return 0;
  endfunction

  // expected outputs of one group, appended in leg-major order
  task automatic model_group(output int worst);
    int sh;
    sh = cur_field + (cur_mode ? 2 : 0);
    worst = 0;
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < Q; n++) begin
        longint ar, ai, br, bi, cr, ci, dr, di, yr, yi, pr, pim, tr, ti;
        int wre, wim, g;
        ar = xr[n];     ai = xi[n];
        br = xr[n+Q];   bi = xi[n+Q];
        cr = xr[n+2*Q]; ci = xi[n+2*Q];
        dr = xr[n+3*Q]; di = xi[n+3*Q];
        case (k)
          0: begin yr = ar + br + cr + dr; yi = ai + bi + ci + di; end
          1: begin yr = (ar - cr) + (bi - di); yi = (ai - ci) - (br - dr); end
          2: begin yr = ar - br + cr - dr; yi = ai - bi + ci - di; end
          default: begin yr = (ar - cr) - (bi - di); yi = (ai - ci) + (br - dr); end
        endcase
        wre = twid(k * n, 1'b0);
        wim = twid(k * n, 1'b1);
        pr  = yr * wre - yi * wim;
        pim = yr * wim + yi * wre;
        tr  = fdiv(fdiv(pr, 14), sh);
        ti  = fdiv(fdiv(pim, 14), sh);
        g = (grade(tr) > grade(ti)) ? grade(tr) : grade(ti);
        if (g > worst) worst = g;
        exp_re[wr] = sat(tr);
        exp_im[wr] = sat(ti);
        exp_leg[wr] = k;
        exp_last[wr] = (k == 3 && n == Q - 1) ? 1 : 0;
        wr++;
      end
    end
  endtask

  task automatic push(input int re, input int im, input bit rs);
    in_val_i = 1'b1;
    in_re_i = 16'(re);
    in_im_i = 16'(im);
    restart_i = rs;
    @(negedge clk);
  endtask

  task automatic send_group(input bit rs);
    int worst;
    model_group(worst);
    for (int i = 0; i < N; i++) push(xr[i], xi[i], rs && i == 0);
    in_val_i = 1'b0;
    restart_i = 1'b0;
    st_exp = rs ? worst : ((worst > st_exp) ? worst : st_exp);
    check(scale_state_o == 2'(st_exp), rs ? "R7 state" : "R8 sticky state",
          int'(scale_state_o), st_exp);
  endtask

  task automatic cfg_write(input int data, input bit we);
    cfg_data_i = 8'(data);
    cfg_we_i = we;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (we) cur_field = data & 7;
  endtask

  task automatic fill(input int amp);
    for (int i = 0; i < N; i++) begin
      xr[i] = rnd(amp);
      xi[i] = rnd(amp);
    end
  endtask

  // output monitor: R2/R3/R4/R5 data, R9 done marker
  always @(negedge clk) begin
    if (!rst && out_val_o) begin
      if (rd >= wr) begin
        check(1'b0, "R10 unexpected output", int'($signed(out_re_o)), 0);
      end else begin
        check($signed(out_re_o) == exp_re[rd] && $signed(out_im_o) == exp_im[rd],
              exp_leg[rd] == 0 ? "R2 leg0 re" : "R3 leg re",
              int'($signed(out_re_o)), exp_re[rd]);
        check(done_n_o == !exp_last[rd], "R9 done_n", int'(done_n_o), int'(!exp_last[rd]));
        rd++;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_val_o == 1'b0, "R1 out_val", int'(out_val_o), 0);
    check(done_n_o == 1'b1, "R1 done_n", int'(done_n_o), 1);
    check(scale_state_o == 2'b00, "R1 state", int'(scale_state_o), 0);
    check(comp_en_o == 1'b0 && last_phase_o == 1'b0, "R1 flags", int'(comp_en_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R6: upper bus bits ignored
    cfg_write(8'hA8, 1'b1);
    for (int i = 0; i < N; i++) begin xr[i] = (i == 0) ? 1000 : 0; xi[i] = 0; end
    send_group(1'b1);

    // R4/R5: sweep every shift in both modes, odd negative values included
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 8; f++) begin
        scale_mode_i = m[0];
        cur_mode = m;
        cfg_write(8'hF0 | f, 1'b1);
        fill(5000 >> (f / 3));
        send_group(1'b1);
      end
    end
    scale_mode_i = 1'b0;
    cur_mode = 0;
    cfg_write(8'h00, 1'b1);

    // R7 guard code, then saturation code
    for (int i = 0; i < N; i++) begin xr[i] = 5000; xi[i] = 0; end
    send_group(1'b1);
    for (int i = 0; i < N; i++) begin xr[i] = 32767; xi[i] = -32768; end
    send_group(1'b1);
    // R8: benign group keeps the saturation state
    fill(100);
    send_group(1'b0);
    // R8: restart clears it
    fill(100);
    send_group(1'b1);

    // R6: write with strobe low changes nothing
    cfg_write(8'h07, 1'b0);
    fill(3000);
    send_group(1'b1);

    // R10: disabled tier ignores inputs and drops pending legs
    comp_en_i = 1'b0;
    @(negedge clk);
    check(comp_en_o == 1'b0, "R10 comp_en_o", int'(comp_en_o), 0);
    for (int i = 0; i < 6; i++) begin
      push(7777, 7777, 1'b0);
      check(out_val_o == 1'b0, "R10 no output", int'(out_val_o), 0);
    end
    in_val_i = 1'b0;
    rd = wr;
    comp_en_i = 1'b1;
    @(negedge clk);
    check(comp_en_o == 1'b1, "R10 comp_en_o", int'(comp_en_o), 1);

    // R11: partial group then restart realigns
    push(4000, 4000, 1'b0);
    push(-4000, 4000, 1'b0);
    in_val_i = 1'b0;
    @(negedge clk);
    fill(2000);
    send_group(1'b1);
    fill(2000);
    send_group(1'b0);

    // R10: last-phase flag forwarded one cycle later
    last_phase_i = 1'b1;
    @(negedge clk);
    check(last_phase_o == 1'b1, "R10 last_phase", int'(last_phase_o), 1);
    last_phase_i = 1'b0;
    @(negedge clk);
    check(last_phase_o == 1'b0, "R10 last_phase", int'(last_phase_o), 0);

    // R3: legs of the last group stay pending, everything else was emitted
    repeat (3) @(negedge clk);
    check(rd == wr - 3 * Q, "R3 output count", rd, wr - 3 * Q);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule